// File: doc/BRIEF.md
# Dual External Interrupt Control Register

This block adds two external interrupt sources to an 8051-style core. All control and status for both sources sits in one 8-bit, bit-addressable register. Each source has four fields in that register: a trigger-type bit, a flag bit, an enable bit and a priority bit. Both interrupt pins are active low. The block passes each pin through a synchroniser. It then detects either a falling edge or a low level, depending on the trigger-type bit.

In edge mode the flag works as a latch. A detected edge sets it, and the core's service acknowledge clears it. In level mode the flag tracks the synchronised, inverted pin every cycle, so it cannot be written. The core reaches the register in two ways: a byte write to its direct address, or a single-bit set or clear through the bit-address space. The block drives one request line and one priority line per source into the core's interrupt logic.

Top module: `xint_ctrl`

## Requirements
- R1: After reset the register reads 8'h00, and every request and priority output is 0.
- R2: A byte write whose address equals REG_ADDR (default 8'hC0) loads all register bits. A byte write to any other address changes nothing.
- R3: A bit operation whose address has bits [7:3] equal to REG_ADDR[7:3] writes bit_val_i into the register bit chosen by address bits [2:0]. Source 0 owns bits [3:0] and source 1 owns bits [7:4]. Within each nibble, bit 0 is the trigger type, bit 1 is the flag, bit 2 is the enable and bit 3 is the priority. For example, setting bit address 8'hC2 sets the enable of source 0.
- R4: Each pin goes through a two-flop synchroniser. A falling edge is a synchronised high followed by a synchronised low. When trigger type is 1 (edge mode), a falling edge sets the flag. The flag becomes visible on the third rising clock edge, counting the edge that first samples the low pin.
- R5: In edge mode, svc_i[n] clears the flag of source n.
- R6: In edge mode, a detected edge sets the flag even when a byte write, a bit write or a service acknowledge targets the same flag in the same cycle.
- R7: When trigger type is 0 (level mode), the flag equals the inverted synchronised pin, with the same latency as R4. Writes to the flag and service acknowledges have no effect on it.
- R8: irq_o[n] is 1 exactly when both the flag and the enable of source n are 1.
- R9: prio_o[n] equals the priority bit of source n.
- R10: reg_rdata_o always shows the current register contents.
- R11: When a byte write and a bit operation occur in the same cycle, the byte write applies first and the bit operation then overrides its one bit.
- R12: In edge mode, a pin that stays low sets the flag only once. After a service clear, the flag stays 0 until a new falling edge arrives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| xint_n_i | input | N_SRC | Active-low external interrupt pins, asynchronous |
| byte_we_i | input | 1 | Byte write strobe |
| byte_addr_i | input | 8 | Direct byte address |
| byte_wdata_i | input | 4*N_SRC | Byte write data |
| bit_we_i | input | 1 | Single-bit write strobe |
| bit_addr_i | input | 8 | Bit address |
| bit_val_i | input | 1 | Value written by a bit operation |
| svc_i | input | N_SRC | Per-source interrupt serviced acknowledge |
| reg_rdata_o | output | 4*N_SRC | Register contents |
| irq_o | output | N_SRC | Per-source interrupt request |
| prio_o | output | N_SRC | Per-source high-priority indication |

## Verification
The bench builds the block with its defaults: two sources, register address 8'hC0 and two synchroniser stages. These values make the full 8-bit layout and the eight bit addresses 8'hC0 to 8'hC7 reachable, including the 8'hC2 enable case. The two-stage synchroniser puts the flag three edges after a pin change, so the bench can land a write or acknowledge exactly on the cycle an edge is detected. This exercises the priority of a hardware set over software, and also mode switches between edge and level tracking on each source.

// File: rtl/xint_pkg.sv
package xint_pkg;
  localparam int FIELD_W = 4;
  localparam int F_TRIG  = 0;
  localparam int F_FLAG  = 1;
  localparam int F_EN    = 2;
  localparam int F_PRI   = 3;

  typedef struct packed {
    logic pri;
    logic en;
    logic flag;
    logic trig;
  } xint_field_t;
endpackage

// File: rtl/xint_sync.sv
module xint_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_n_i,
  output logic lvl_o,
  output logic fall_o
);
  logic [STAGES-1:0] chain_q;
  logic              last_q;

  // pins idle high: reset chain to 1 so no false edge after reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '1;
      last_q  <= 1'b1;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], pin_n_i};
      last_q  <= chain_q[STAGES-1];
    end
  end

  assign lvl_o  = ~chain_q[STAGES-1];
  assign fall_o = last_q & ~chain_q[STAGES-1];
endmodule

// File: rtl/xint_access.sv
module xint_access #(
  parameter int          REG_W    = 8,
  parameter logic [7:0]  REG_ADDR = 8'hC0
) (
  input  logic             byte_we_i,
  input  logic [7:0]       byte_addr_i,
  input  logic [REG_W-1:0] byte_wdata_i,
  input  logic             bit_we_i,
  input  logic [7:0]       bit_addr_i,
  input  logic             bit_val_i,
  output logic [REG_W-1:0] wmask_o,
  output logic [REG_W-1:0] wval_o
);
  localparam int IDX_W = $clog2(REG_W);

  logic byte_hit;
  logic bit_hit;

  assign byte_hit = byte_we_i && (byte_addr_i == REG_ADDR);
  assign bit_hit  = bit_we_i && (bit_addr_i[7:IDX_W] == REG_ADDR[7:IDX_W]);

  always_comb begin
    wmask_o = '0;
    wval_o  = '0;
    if (byte_hit) begin
      wmask_o = '1;
      wval_o  = byte_wdata_i;
    end
    // bit op overrides its bit of a same-cycle byte write
    for (int i = 0; i < REG_W; i++) begin
      if (bit_hit && (bit_addr_i[IDX_W-1:0] == IDX_W'(i))) begin
        wmask_o[i] = 1'b1;
        wval_o[i]  = bit_val_i;
      end
    end
  end
endmodule

// File: rtl/xint_src.sv
module xint_src
  import xint_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        fall_i,
  input  logic        lvl_i,
  input  logic        svc_i,
  input  logic [3:0]  wr_mask_i,
  input  logic [3:0]  wr_val_i,
  output xint_field_t field_o,
  output logic        irq_o,
  output logic        prio_o
);
  xint_field_t field_q;
  xint_field_t field_d;

  always_comb begin
    field_d = xint_field_t'((field_q & ~wr_mask_i) | (wr_val_i & wr_mask_i));
    if (field_q.trig) begin
      if (fall_i)                 field_d.flag = 1'b1;
      else if (!wr_mask_i[F_FLAG]) field_d.flag = svc_i ? 1'b0 : field_q.flag;
    end else begin
      field_d.flag = lvl_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) field_q <= '0;
    else         field_q <= field_d;
  end

  assign field_o = field_q;
  assign irq_o   = field_q.flag & field_q.en;
  assign prio_o  = field_q.pri;
endmodule

// File: rtl/xint_ctrl.sv
module xint_ctrl
  import xint_pkg::*;
#(
  parameter int         N_SRC       = 2,
  parameter logic [7:0] REG_ADDR    = 8'hC0,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [N_SRC-1:0]         xint_n_i,
  input  logic                     byte_we_i,
  input  logic [7:0]               byte_addr_i,
  input  logic [FIELD_W*N_SRC-1:0] byte_wdata_i,
  input  logic                     bit_we_i,
  input  logic [7:0]               bit_addr_i,
  input  logic                     bit_val_i,
  input  logic [N_SRC-1:0]         svc_i,
  output logic [FIELD_W*N_SRC-1:0] reg_rdata_o,
  output logic [N_SRC-1:0]         irq_o,
  output logic [N_SRC-1:0]         prio_o
);
  localparam int REG_W = FIELD_W * N_SRC;

  logic [REG_W-1:0] wmask;
  logic [REG_W-1:0] wval;
  logic [N_SRC-1:0] fall;
  logic [N_SRC-1:0] lvl;

  xint_access #(.REG_W(REG_W), .REG_ADDR(REG_ADDR)) i_access (
    .byte_we_i   (byte_we_i),
    .byte_addr_i (byte_addr_i),
    .byte_wdata_i(byte_wdata_i),
    .bit_we_i    (bit_we_i),
    .bit_addr_i  (bit_addr_i),
    .bit_val_i   (bit_val_i),
    .wmask_o     (wmask),
    .wval_o      (wval)
  );

  for (genvar n = 0; n < N_SRC; n++) begin : g_src
    xint_field_t field;

    xint_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .pin_n_i(xint_n_i[n]),
      .lvl_o  (lvl[n]),
      .fall_o (fall[n])
    );

    xint_src i_src (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .fall_i   (fall[n]),
      .lvl_i    (lvl[n]),
      .svc_i    (svc_i[n]),
      .wr_mask_i(wmask[n*FIELD_W +: FIELD_W]),
      .wr_val_i (wval[n*FIELD_W +: FIELD_W]),
      .field_o  (field),
      .irq_o    (irq_o[n]),
      .prio_o   (prio_o[n])
    );

    assign reg_rdata_o[n*FIELD_W +: FIELD_W] = field;
  end
endmodule

// File: rtl/xint_ctrl_chk.sv
module xint_ctrl_chk #(
  parameter int N_SRC = 2
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [N_SRC-1:0]     fall,
  input logic [N_SRC-1:0]     lvl,
  input logic [N_SRC-1:0]     svc_i,
  input logic [4*N_SRC-1:0]   wmask,
  input logic [4*N_SRC-1:0]   wval,
  input logic [4*N_SRC-1:0]   reg_rdata_o,
  input logic [N_SRC-1:0]     irq_o,
  input logic [N_SRC-1:0]     prio_o
);
  for (genvar n = 0; n < N_SRC; n++) begin : g_n
    AST_EDGE_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (reg_rdata_o[4*n] && fall[n]) |=> reg_rdata_o[4*n+1]); // R6
    AST_SVC_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (reg_rdata_o[4*n] && !fall[n] && svc_i[n] && !wmask[4*n+1]) |=> !reg_rdata_o[4*n+1]); // R5
    AST_EDGE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (reg_rdata_o[4*n] && !fall[n] && !svc_i[n] && !wmask[4*n+1]) |=> $stable(reg_rdata_o[4*n+1])); // R12
    AST_EDGE_FLAG_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (reg_rdata_o[4*n] && !fall[n] && wmask[4*n+1]) |=> reg_rdata_o[4*n+1] == $past(wval[4*n+1])); // R3
    AST_LEVEL_FOLLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !reg_rdata_o[4*n] |=> reg_rdata_o[4*n+1] == $past(lvl[n])); // R7
    AST_IRQ_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o[n] |-> (reg_rdata_o[4*n+2] && reg_rdata_o[4*n+1])); // R8
    AST_PRIO_MIRROR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      prio_o[n] == reg_rdata_o[4*n+3]); // R9
  end

  for (genvar i = 0; i < 4*N_SRC; i++) begin : g_bit
    if ((i % 4) != 1) begin : g_plain
      AST_FIELD_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wmask[i] |=> reg_rdata_o[i] == $past(wval[i])); // R2
      AST_FIELD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wmask[i] |=> $stable(reg_rdata_o[i])); // R10
    end
  end
endmodule

bind xint_ctrl xint_ctrl_chk #(.N_SRC(N_SRC)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .fall       (fall),
  .lvl        (lvl),
  .svc_i      (svc_i),
  .wmask      (wmask),
  .wval       (wval),
  .reg_rdata_o(reg_rdata_o),
  .irq_o      (irq_o),
  .prio_o     (prio_o)
);

// File: tb/test_xint_ctrl.sv
module test_xint_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] pin_n = 2'b11;
  logic       byte_we = 1'b0;
  logic [7:0] byte_addr = '0;
  logic [7:0] byte_wdata = '0;
  logic       bit_we = 1'b0;
  logic [7:0] bit_addr = '0;
  logic       bit_val = 1'b0;
  logic [1:0] svc = '0;
  logic [7:0] rdata;
  logic [1:0] irq;
  logic [1:0] prio;

  int    errors = 0;
  int    checks = 0;
  int    cyc = 0;
  string phase = "R1";

  always #10 clk = ~clk;

  xint_ctrl i_xint_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .xint_n_i(pin_n),
    .byte_we_i(byte_we), .byte_addr_i(byte_addr), .byte_wdata_i(byte_wdata),
    .bit_we_i(bit_we), .bit_addr_i(bit_addr), .bit_val_i(bit_val),
    .svc_i(svc), .reg_rdata_o(rdata), .irq_o(irq), .prio_o(prio)
  );

  // behavioural reference
  logic [7:0] m_reg, m_nr, m_mk;
  logic [1:0] m_s1, m_s2, m_s3;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_reg = '0; m_s1 = '1; m_s2 = '1; m_s3 = '1;
    end else begin
      m_nr = m_reg; m_mk = '0;
      if (byte_we && byte_addr == 8'hC0) begin m_nr = byte_wdata; m_mk = 8'hFF; end
      if (bit_we && bit_addr[7:3] == 5'h18) begin
        m_nr[bit_addr[2:0]] = bit_val; m_mk[bit_addr[2:0]] = 1'b1;
      end
      for (int n = 0; n < 2; n++) begin
        if (m_reg[4*n]) begin
          if (m_s3[n] && !m_s2[n]) m_nr[4*n+1] = 1'b1;
          else if (!m_mk[4*n+1] && svc[n]) m_nr[4*n+1] = 1'b0;
        end else begin
          m_nr[4*n+1] = !m_s2[n];
        end
      end
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = pin_n; m_reg = m_nr;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      logic [1:0] e_irq, e_prio;
      e_irq  = {m_reg[5] & m_reg[6], m_reg[1] & m_reg[2]};
      e_prio = {m_reg[7], m_reg[3]};
      checks++;
      if (rdata !== m_reg || irq !== e_irq || prio !== e_prio) begin
        errors++;
        $display("FAIL %s model cycle %0d: act reg=%h irq=%b prio=%b exp reg=%h irq=%b prio=%b",
                 phase, cyc, rdata, irq, prio, m_reg, e_irq, e_prio);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 20000) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: act %h exp %h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_byte(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); byte_we = 1'b1; byte_addr = a; byte_wdata = d;
    @(negedge clk); byte_we = 1'b0;
  endtask

  task automatic wr_bit(input logic [7:0] a, input logic v);
    @(negedge clk); bit_we = 1'b1; bit_addr = a; bit_val = v;
    @(negedge clk); bit_we = 1'b0;
  endtask

  task automatic ack(input logic [1:0] s);
    @(negedge clk); svc = s;
    @(negedge clk); svc = '0;
  endtask

  initial begin
    idle(2);
    rst_n = 1'b1;
    idle(2);
    phase = "R1";
    chk("R1 reg", rdata, 8'h00);
    chk("R1 irq/prio", {4'h0, irq, prio}, 8'h00);

    phase = "R2";
    wr_byte(8'hC0, 8'h5D);
    chk("R2 byte load", rdata, 8'h5D);
    wr_byte(8'hC1, 8'hFF);
    chk("R2 other addr", rdata, 8'h5D);

    phase = "R3";
    wr_byte(8'hC0, 8'h00);
    wr_bit(8'hC2, 1'b1);
    chk("R3 set C2", rdata, 8'h04);
    wr_bit(8'hC7, 1'b1);
    chk("R3 set C7", rdata, 8'h84);
    wr_bit(8'hC2, 1'b0);
    chk("R3 clr C2", rdata, 8'h80);

    phase = "R11";
    @(negedge clk);
    byte_we = 1'b1; byte_addr = 8'hC0; byte_wdata = 8'h0F;
    bit_we = 1'b1; bit_addr = 8'hC0; bit_val = 1'b0;
    @(negedge clk); byte_we = 1'b0; bit_we = 1'b0;
    chk("R11 byte then bit", rdata, 8'h0C);

    phase = "R4";
    wr_byte(8'hC0, 8'h55);
    @(negedge clk); pin_n[0] = 1'b0;
    idle(1);
    chk("R4 not yet", rdata, 8'h55);
    idle(2);
    chk("R4 edge set", rdata, 8'h57);
    chk("R8 irq on", {6'h0, irq}, 8'h01);

    phase = "R12";
    ack(2'b01);
    chk("R5 svc clear", rdata, 8'h55);
    idle(4);
    chk("R12 held low no reset", rdata, 8'h55);
    pin_n[0] = 1'b1;
    idle(4);

    phase = "R6";
    wr_bit(8'hC1, 1'b1);
    chk("R3 edge flag write", rdata, 8'h57);
    pin_n[0] = 1'b0;
    idle(2);
    bit_we = 1'b1; bit_addr = 8'hC1; bit_val = 1'b0; svc = 2'b01;
    @(negedge clk); bit_we = 1'b0; svc = '0;
    chk("R6 hw set wins", rdata, 8'h57);
    ack(2'b01);
    pin_n[0] = 1'b1;
    idle(4);

    phase = "R8";
    wr_byte(8'hC0, 8'h11);
    pin_n[1] = 1'b0;
    idle(4);
    chk("R8 flag set", rdata, 8'h31);
    chk("R8 disabled no irq", {6'h0, irq}, 8'h00);
    pin_n[1] = 1'b1;
    idle(4);

    phase = "R7";
    wr_byte(8'hC0, 8'h44);
    chk("R7 level reg", rdata, 8'h44);
    pin_n[1] = 1'b0;
    idle(4);
    chk("R7 level follow", rdata, 8'h64);
    chk("R7 level irq", {6'h0, irq}, 8'h02);
    wr_bit(8'hC1, 1'b1);
    chk("R7 flag write ignored", rdata, 8'h64);
    ack(2'b10);
    chk("R7 svc ignored", rdata, 8'h64);
    pin_n[1] = 1'b1;
    idle(4);
    chk("R7 level release", rdata, 8'h44);

    phase = "R9";
    wr_byte(8'hC0, 8'h88);
    chk("R9 prio", {6'h0, prio}, 8'h03);
    chk("R10 readback", rdata, 8'h88);

    idle(3);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule